// File: doc/BRIEF.md
# Word Synchronization Tracker

This block decides whether a receive lane has word lock. It takes one decoded 10-bit code-group report per cycle. Each report has a valid strobe, a flag saying an alignment pattern such as a comma was seen, and a flag saying the code-group was invalid or carried a disparity error. From these it drives three outputs: a level that says the lane is synchronized, a one-cycle pulse for every alignment pattern seen, and a one-cycle request to the upstream bit-slip logic to hunt for a new word boundary.

Three runtime thresholds set the behaviour. The first is how many patterns are needed to gain lock. The second is how many accumulated errors drop lock. The third is how long a clean run must be to forgive one error. Lock is lost only through an error counter. Each error raises the counter. Each completed run of clean words lowers it by one, and when it reaches zero the lane is back to full lock. A manual realign input drops lock at once and makes the very next pattern restore it.

Top module: `wsync_fsm`

## Requirements
- R1: After reset, `sync_ok`, `pat_det` and `realign_req` are low and all internal counts are zero.
- R2: Starting from loss of sync, `sync_ok` goes high in the cycle after the pattern word that brings the count of accepted patterns to `acq_need`. An `acq_need` of 0 behaves like 1.
- R3: A word with `cg_valid` low has no effect. While patterns are being gathered, an error word clears the pattern count to zero.
- R4: A valid word that carries both `comma_seen` and `code_err` is an error and not a pattern, so it raises no `pat_det`.
- R5: While in sync, each error word raises the error count by one. When the count reaches `loss_need` (0 behaves like 1), `sync_ok` is low from the next cycle.
- R6: While the error count is nonzero, each run of `good_need` consecutive valid error-free words (0 behaves like 1) lowers it by one. An error word restarts the run from zero.
- R7: When the error count returns to zero, the lane is again fully locked, so a further `loss_need` errors are needed to drop sync.
- R8: `pat_det` is high for exactly the cycle after each valid error-free word with `comma_seen`, in every state.
- R9: `realign_req` is high for exactly one cycle, the cycle after the block moves to loss of sync from any other state. It stays low while already in loss of sync.
- R10: `manual_realign` high forces loss of sync with all counts cleared, taking priority over the word in the same cycle. The next valid pattern word then restores sync whatever `acq_need` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cg_valid | input | 1 | A code-group report is present this cycle |
| comma_seen | input | 1 | The code-group is an alignment pattern |
| code_err | input | 1 | The code-group is invalid or has a disparity error |
| manual_realign | input | 1 | Force loss of sync and lock to the next pattern |
| acq_need | input | 8 | Patterns needed to gain sync |
| loss_need | input | 6 | Errors needed to lose sync |
| good_need | input | 8 | Clean words needed to forgive one error |
| sync_ok | output | 1 | Lane is word-synchronized |
| pat_det | output | 1 | Pulse one cycle after an accepted pattern |
| realign_req | output | 1 | Pulse asking the aligner to seek a new boundary |

## Verification
The hardest case to reach is an error count that goes up and down several times without ever touching the loss threshold. That needs errors spaced so that some clean runs complete and others are cut off one word short. The stimulus builds these sequences on purpose: three clean words followed by an error, and full runs of clean words between errors. It then checks that the exact number of remaining errors drops sync. A long random stretch with small thresholds, mixing errors and patterns, keeps the block crossing between the reduced-lock and full-lock states. A behavioural model follows every cycle of it.

// File: rtl/wsync_pkg.sv
package wsync_pkg;

  typedef enum logic [1:0] {
    ST_HUNT       = 2'd0,
    ST_GATHER     = 2'd1,
    ST_LOCKED     = 2'd2,
    ST_LOCKED_ERR = 2'd3
  } wsync_state_e;

  // A threshold of zero is treated as one.
  function automatic int unsigned eff_need(input int unsigned need);
    return (need == 0) ? 1 : need;
  endfunction

  function automatic logic reached(input int unsigned cnt, input int unsigned need);
    return cnt >= eff_need(need);
  endfunction

endpackage

// File: rtl/wsync_classify.sv
module wsync_classify (
  input  logic cg_valid,
  input  logic comma_seen,
  input  logic code_err,
  output logic w_err,
  output logic w_pat,
  output logic w_good
);
  // Error wins over pattern in the same word.
  always_comb begin
    w_err  = cg_valid & code_err;
    w_good = cg_valid & ~code_err;
    w_pat  = cg_valid & comma_seen & ~code_err;
  end
endmodule

// File: rtl/wsync_flop.sv
module wsync_flop #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/wsync_core.sv
module wsync_core
  import wsync_pkg::*;
#(
  parameter int PAT_W = 8,
  parameter int ERR_W = 6,
  parameter int RUN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             w_err,
  input  logic             w_pat,
  input  logic             w_good,
  input  logic             force_hunt,
  input  logic [PAT_W-1:0] acq_need,
  input  logic [ERR_W-1:0] loss_need,
  input  logic [RUN_W-1:0] good_need,
  output wsync_state_e     state,
  output logic             gain_evt,
  output logic             lose_evt,
  output logic             forgive_evt,
  output logic [ERR_W-1:0] err_cnt
);
  wsync_state_e     st_n;
  logic [PAT_W-1:0] pat_cnt, pat_cnt_n;
  logic [ERR_W-1:0] err_cnt_n;
  logic [RUN_W-1:0] run_cnt, run_cnt_n;
  logic             armed, armed_n;

  always_comb begin
    st_n        = state;
    pat_cnt_n   = pat_cnt;
    err_cnt_n   = err_cnt;
    run_cnt_n   = run_cnt;
    armed_n     = armed;
    gain_evt    = 1'b0;
    lose_evt    = 1'b0;
    forgive_evt = 1'b0;
    if (force_hunt) begin
      lose_evt  = (state != ST_HUNT);
      st_n      = ST_HUNT;
      pat_cnt_n = '0;
      err_cnt_n = '0;
      run_cnt_n = '0;
      armed_n   = 1'b1;
    end else begin
      unique case (state)
        ST_HUNT, ST_GATHER: begin
          if (w_err) begin
            pat_cnt_n = '0;
          end else if (w_pat) begin
            if (armed || reached(32'(pat_cnt) + 32'd1, 32'(acq_need))) begin
              gain_evt  = 1'b1;
              st_n      = ST_LOCKED;
              pat_cnt_n = '0;
              armed_n   = 1'b0;
            end else begin
              pat_cnt_n = pat_cnt + 1'b1;
              st_n      = ST_GATHER;
            end
          end
        end
        ST_LOCKED: begin
          if (w_err) begin
            run_cnt_n = '0;
            if (reached(32'd1, 32'(loss_need))) begin
              lose_evt = 1'b1;
              st_n     = ST_HUNT;
            end else begin
              err_cnt_n = ERR_W'(1);
              st_n      = ST_LOCKED_ERR;
            end
          end
        end
        ST_LOCKED_ERR: begin
          if (w_err) begin
            run_cnt_n = '0;
            if (reached(32'(err_cnt) + 32'd1, 32'(loss_need))) begin
              lose_evt  = 1'b1;
              st_n      = ST_HUNT;
              err_cnt_n = '0;
            end else begin
              err_cnt_n = err_cnt + 1'b1;
            end
          end else if (w_good) begin
            if (reached(32'(run_cnt) + 32'd1, 32'(good_need))) begin
              forgive_evt = 1'b1;
              run_cnt_n   = '0;
              err_cnt_n   = err_cnt - 1'b1;
              if (err_cnt == ERR_W'(1)) st_n = ST_LOCKED;
            end else begin
              run_cnt_n = run_cnt + 1'b1;
            end
          end
        end
        default: st_n = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_HUNT;
      pat_cnt <= '0;
      err_cnt <= '0;
      run_cnt <= '0;
      armed   <= 1'b0;
    end else begin
      state   <= st_n;
      pat_cnt <= pat_cnt_n;
      err_cnt <= err_cnt_n;
      run_cnt <= run_cnt_n;
      armed   <= armed_n;
    end
  end
endmodule

// File: rtl/wsync_fsm.sv
module wsync_fsm
  import wsync_pkg::*;
#(
  parameter int PAT_W = 8,
  parameter int ERR_W = 6,
  parameter int RUN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cg_valid,
  input  logic             comma_seen,
  input  logic             code_err,
  input  logic             manual_realign,
  input  logic [PAT_W-1:0] acq_need,
  input  logic [ERR_W-1:0] loss_need,
  input  logic [RUN_W-1:0] good_need,
  output logic             sync_ok,
  output logic             pat_det,
  output logic             realign_req
);
  logic             w_err, w_pat, w_good;
  logic             gain_evt, lose_evt, forgive_evt;
  logic [ERR_W-1:0] err_cnt;
  wsync_state_e     state;

  wsync_classify u_classify (
    .cg_valid   (cg_valid),
    .comma_seen (comma_seen),
    .code_err   (code_err),
    .w_err      (w_err),
    .w_pat      (w_pat),
    .w_good     (w_good)
  );

  wsync_core #(.PAT_W(PAT_W), .ERR_W(ERR_W), .RUN_W(RUN_W)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .w_err       (w_err),
    .w_pat       (w_pat),
    .w_good      (w_good),
    .force_hunt  (manual_realign),
    .acq_need    (acq_need),
    .loss_need   (loss_need),
    .good_need   (good_need),
    .state       (state),
    .gain_evt    (gain_evt),
    .lose_evt    (lose_evt),
    .forgive_evt (forgive_evt),
    .err_cnt     (err_cnt)
  );

  wsync_flop #(.WIDTH(2)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({w_pat, lose_evt}),
    .q     ({pat_det, realign_req})
  );

  assign sync_ok = (state == ST_LOCKED) || (state == ST_LOCKED_ERR);
endmodule

// File: rtl/wsync_fsm_chk.sv
module wsync_fsm_chk #(
  parameter int ERR_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cg_valid,
  input logic             comma_seen,
  input logic             code_err,
  input logic             manual_realign,
  input logic             sync_ok,
  input logic             pat_det,
  input logic             realign_req,
  input logic             w_err,
  input logic             w_pat,
  input logic [ERR_W-1:0] err_cnt
);
  AST_GAIN_NEEDS_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_ok) |-> $past(w_pat)); // R2

  AST_LOSS_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_ok) |-> ($past(w_err) || $past(manual_realign))); // R5

  AST_NO_ERRCNT_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_ok |-> (err_cnt == '0)); // R5

  AST_PATDET_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    pat_det |-> $past(cg_valid && comma_seen && !code_err)); // R8

  AST_REALIGN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    realign_req |=> !realign_req); // R9

  AST_REALIGN_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    realign_req |-> !sync_ok); // R9

  AST_MANUAL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    manual_realign |=> !sync_ok); // R10
endmodule

bind wsync_fsm wsync_fsm_chk #(.ERR_W(ERR_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cg_valid       (cg_valid),
  .comma_seen     (comma_seen),
  .code_err       (code_err),
  .manual_realign (manual_realign),
  .sync_ok        (sync_ok),
  .pat_det        (pat_det),
  .realign_req    (realign_req),
  .w_err          (w_err),
  .w_pat          (w_pat),
  .err_cnt        (err_cnt)
);

// File: tb/wsync_fsm_bench.sv
module wsync_fsm_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cg_valid = 1'b0, comma_seen = 1'b0, code_err = 1'b0, manual_realign = 1'b0;
  logic [7:0] acq_need = 8'd3;
  logic [5:0] loss_need = 6'd3;
  logic [7:0] good_need = 8'd4;
  logic       sync_ok, pat_det, realign_req;

  int compared = 0;
  int mismatched = 0;
  string phase = "R1";

  // behavioural reference state
  int m_st = 0;  // 0 hunt, 1 gathering, 2 locked, 3 locked with errors
  int m_pc = 0, m_ec = 0, m_gc = 0;
  bit m_arm = 0;
  bit e_sync = 0, e_pd = 0, e_rq = 0;

  always #10 clk = ~clk;

  wsync_fsm u_wsync_fsm (
    .clk(clk), .rst_n(rst_n), .cg_valid(cg_valid), .comma_seen(comma_seen),
    .code_err(code_err), .manual_realign(manual_realign), .acq_need(acq_need),
    .loss_need(loss_need), .good_need(good_need), .sync_ok(sync_ok),
    .pat_det(pat_det), .realign_req(realign_req)
  );

  task automatic chk(input string tag, input logic act, input logic exp, input string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic drop_sync();
    e_rq = 1; m_st = 0; m_pc = 0; m_ec = 0; m_gc = 0;
  endtask

  task automatic model(input bit v, input bit c, input bit e, input bit m);
    int na, nl, ng;
    na = (acq_need == 0) ? 1 : int'(acq_need);
    nl = (loss_need == 0) ? 1 : int'(loss_need);
    ng = (good_need == 0) ? 1 : int'(good_need);
    e_pd = v && c && !e;
    e_rq = 0;
    if (m) begin
      e_rq = (m_st != 0);
      m_st = 0; m_pc = 0; m_ec = 0; m_gc = 0; m_arm = 1;
    end else if (v && e) begin
      if (m_st == 1) m_pc = 0;
      else if (m_st == 2) begin
        if (nl <= 1) drop_sync();
        else begin m_st = 3; m_ec = 1; m_gc = 0; end
      end else if (m_st == 3) begin
        m_gc = 0;
        if (m_ec + 1 >= nl) drop_sync();
        else m_ec++;
      end
    end else if (v) begin
      if (m_st <= 1 && c) begin
        if (m_arm || m_pc + 1 >= na) begin m_st = 2; m_pc = 0; m_arm = 0; end
        else begin m_pc++; m_st = 1; end
      end else if (m_st == 3) begin
        m_gc++;
        if (m_gc >= ng) begin
          m_gc = 0; m_ec--;
          if (m_ec == 0) m_st = 2;
        end
      end
    end
    e_sync = (m_st >= 2);
  endtask

  // one word per cycle; inputs change at the falling edge, outputs sampled at the next falling edge
  task automatic w(input bit v, input bit c, input bit e, input bit m = 0);
    cg_valid = v; comma_seen = c; code_err = e; manual_realign = m;
    @(posedge clk);
    model(v, c, e, m);
    @(negedge clk);
    chk(phase, sync_ok, e_sync, "sync_ok model");
    chk(phase, pat_det, e_pd, "pat_det model");
    chk(phase, realign_req, e_rq, "realign_req model");
  endtask

  task automatic pats(input int n);
    for (int i = 0; i < n; i++) w(1, 1, 0);
  endtask

  task automatic goods(input int n);
    for (int i = 0; i < n; i++) w(1, 0, 0);
  endtask

  initial begin
    #(20 * 150000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    phase = "R1";
    chk("R1", sync_ok, 0, "sync_ok after reset");
    chk("R1", pat_det, 0, "pat_det after reset");
    chk("R1", realign_req, 0, "realign_req after reset");

    phase = "R2";
    w(1, 1, 0); w(1, 1, 0);
    w(0, 1, 0);                                   // R3: not valid, ignored
    chk("R3", sync_ok, 0, "invalid comma word counted");
    w(1, 1, 0);
    chk("R2", sync_ok, 1, "sync after third pattern");
    chk("R8", pat_det, 1, "pat_det after pattern");

    phase = "R5";
    w(1, 0, 1); chk("R5", sync_ok, 1, "one error");
    w(1, 0, 1); chk("R5", sync_ok, 1, "two errors");
    w(1, 0, 1); chk("R5", sync_ok, 0, "three errors");
    chk("R9", realign_req, 1, "pulse on loss");
    w(1, 0, 0); chk("R9", realign_req, 0, "pulse width");
    w(1, 0, 1); chk("R9", realign_req, 0, "error while hunting");

    phase = "R3";
    w(1, 1, 0); w(1, 1, 0); w(1, 0, 1); w(1, 1, 0); w(1, 1, 0);
    chk("R3", sync_ok, 0, "pattern count cleared by error");
    w(1, 1, 0); chk("R3", sync_ok, 1, "sync after fresh run");

    phase = "R4";
    w(1, 1, 1); chk("R4", pat_det, 0, "comma with error not a pattern");
    w(1, 1, 1); w(1, 1, 1);
    chk("R4", sync_ok, 0, "comma with error counted as error");

    phase = "R6";
    pats(3);
    w(1, 0, 1); goods(3); w(1, 0, 1); goods(1); w(1, 0, 1);
    chk("R6", sync_ok, 0, "run restarted by error");

    phase = "R7";
    pats(3);
    w(1, 0, 1); goods(3); w(1, 0, 1); goods(4);
    chk("R6", sync_ok, 1, "one decrement");
    goods(4);
    w(1, 0, 1); w(1, 0, 1);
    chk("R7", sync_ok, 1, "count back to zero");
    w(1, 0, 1);
    chk("R7", sync_ok, 0, "full threshold after recovery");

    phase = "R8";
    acq_need = 8'd200;
    for (int i = 0; i < 5; i++) begin
      w(1, 1, 0); chk("R8", pat_det, 1, "pattern while gathering");
      w(1, 0, 0); chk("R8", pat_det, 0, "no pattern");
    end

    phase = "R10";
    acq_need = 8'd3;
    w(1, 0, 1);
    pats(3);
    acq_need = 8'd5;
    w(0, 0, 0, 1);
    chk("R10", sync_ok, 0, "manual drop");
    chk("R9", realign_req, 1, "manual pulse");
    w(1, 1, 0);
    chk("R10", sync_ok, 1, "next pattern locks");
    w(1, 1, 0, 1);
    chk("R10", sync_ok, 0, "manual wins over pattern");
    w(0, 0, 0, 1);
    chk("R9", realign_req, 0, "manual while hunting");
    w(1, 1, 0);
    chk("R10", sync_ok, 1, "armed lock");

    phase = "R2";
    acq_need = 8'd0; loss_need = 6'd0; good_need = 8'd0;
    w(1, 0, 1);
    w(1, 1, 0); chk("R2", sync_ok, 1, "zero acquire threshold");
    phase = "R5";
    w(1, 0, 1); chk("R5", sync_ok, 0, "zero loss threshold");

    phase = "R7";
    for (int blk = 0; blk < 40; blk++) begin
      acq_need  = 8'($urandom_range(0, 4));
      loss_need = 6'($urandom_range(0, 5));
      good_need = 8'($urandom_range(0, 4));
      for (int i = 0; i < 80; i++) begin
        int r;
        r = $urandom_range(0, 99);
        w(r < 90, $urandom_range(0, 2) == 0, r < 12, $urandom_range(0, 99) == 0);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule